// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block drives three serial audio data lines from parallel left/right samples. It is a slave: an external master supplies the bit clock and the frame clock. Both arrive as levels that are already synchronous to the system clock. The block finds falling bit-clock edges by sampling against that clock and changes its data lines only at those edges. Data go out most significant bit first, in two's complement.

Two selects are set independently. One chooses how the word sits inside each half-frame: right-justified, left-justified or I2S. The other chooses the word length: 16, 18, 20 or 24 bits. Every sample arrives as 24 bits and is cut to the chosen length. One sample pair per line is latched when a left channel begins, and a one-cycle take pulse tells the source that it may present the next pair. A quad-line input parks the third line. A power-down input silences every line and restarts the framing logic. All lines share one format setting, which is changed only while power-down is high.

Top module: `pcm_serial_tx`

## Requirements
- R1: A data line changes only on the first system clock edge that samples the bit clock low after it was high (one clock of latency), and holds its value until the next such edge.
- R2: Framing code 2 (left-justified): a high frame clock marks the left channel, and the MSB appears at the first bit clock of each half-frame.
- R3: Framing code 3 (I2S): a low frame clock marks the left channel, and the MSB appears one bit clock after the frame clock edge. With 16-bit words at 16 bit clocks per half, the LSB goes out on the first bit clock of the following half.
- R4: Framing code 0 (right-justified): the LSB falls on the last bit clock of the half-frame, using the length of the half just finished, and the line is low before the word starts. The first half after power-down is low because no length has been measured yet.
- R5: Framing code 1 is reserved, and every data line stays low while it is selected.
- R6: Word-length codes 0, 1, 2 and 3 select 16, 18, 20 and 24 bits. A shorter word keeps the top bits of the 24-bit sample, and the line is low after the word ends in the left-justified and I2S framings.
- R7: Line i takes its samples from bits [24*i+23 : 24*i] of the left and right sample inputs. Both are latched at the bit clock that starts a left channel. The right channel of that frame uses the latched value, so later input changes have no effect. smp_take pulses for one system clock, one clock after the latch.
- R8: With quad_mode high, line 2 stays low and lines 0 and 1 behave as normal.
- R9: While pwr_down is high, every data line is low from the next system clock and no sample is taken. After release, framing restarts at the next left channel.
- R10: During and right after synchronous reset, every data line and smp_take are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_down | input | 1 | Silences the lines and restarts framing when high |
| fmt_sel | input | 2 | Framing: 0 right-justified, 1 reserved, 2 left-justified, 3 I2S |
| wlen_sel | input | 2 | Word length: 0 16, 1 18, 2 20, 3 24 bits |
| quad_mode | input | 1 | Parks line 2 when high |
| bclk | input | 1 | Bit clock, sampled by clk |
| lrck | input | 1 | Frame clock, sampled by clk |
| smp_left | input | 72 | Left samples, 24 bits per line, line 0 in the low bits |
| smp_right | input | 72 | Right samples, same packing |
| smp_take | output | 1 | One-cycle pulse after a sample pair is latched |
| sdo | output | 3 | Serial data lines, bit i is line i |

## Verification
The assertions assume that both clocks are synchronous to clk and that each bit-clock level lasts at least one system clock. They also assume that the frame clock changes only together with a falling bit clock, that every half-frame has the same number of bit clocks, and that the selects and quad_mode change only under power-down or reset. The stimulus keeps a four-clock bit period, moves the frame clock only in the cycle where the bit clock falls, and changes the selects only with pwr_down high. It uses 16 to 32 bit clocks per half, never fewer than the word needs.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;

    localparam int unsigned SMP_W      = 24;
    localparam int unsigned HALF_SLOTS = 32;
    localparam int unsigned POS_W      = $clog2(HALF_SLOTS);
    localparam int unsigned LEN_W      = $clog2(HALF_SLOTS + 1);
    localparam int unsigned IDX_W      = $clog2(SMP_W);

    typedef enum logic [1:0] {
        FMT_RJ   = 2'd0,
        FMT_RSVD = 2'd1,
        FMT_LJ   = 2'd2,
        FMT_I2S  = 2'd3
    } frame_fmt_e;

    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_18 = 2'd1,
        WL_20 = 2'd2,
        WL_24 = 2'd3
    } word_len_e;

    // Timing of the current bit-clock falling edge, in the framing-adjusted domain
    typedef struct packed {
        logic             tick;
        logic             is_left;
        logic             left_start;
        logic             len_ok;
        logic [POS_W-1:0] pos;
        logic [LEN_W-1:0] half_len;
    } slot_t;

    typedef struct packed {
        logic             active;
        logic [IDX_W-1:0] idx;
    } bit_sel_t;

    function automatic int unsigned word_bits(input word_len_e c);
        case (c)
            WL_16:   return 16;
            WL_18:   return 18;
            WL_20:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic logic [POS_W-1:0] pos_step(input logic [POS_W-1:0] p);
        return (p == POS_W'(HALF_SLOTS - 1)) ? p : p + 1'b1;
    endfunction

endpackage

// File: rtl/pcm_tx_timebase.sv
module pcm_tx_timebase
    import pcm_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       pd,
    input  frame_fmt_e fmt,
    input  logic       bclk,
    input  logic       lrck,
    output slot_t      slot
);

    logic             bclk_q;
    logic             lr_prev;
    logic             eff_last;
    logic             seen;
    logic             len_ok_q;
    logic [POS_W-1:0] pos_q;
    logic [LEN_W-1:0] len_q;

    logic             tick;
    logic             eff_now;
    logic             flip;
    logic [LEN_W-1:0] len_new;

    // I2S is handled as left-justified framing on a frame clock delayed by one bit
    always_comb begin
        tick    = bclk_q & ~bclk;
        eff_now = (fmt == FMT_I2S) ? ~lr_prev : lrck;
        flip    = eff_now ^ eff_last;
        len_new = LEN_W'(pos_q) + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bclk_q <= 1'b0;
        end else begin
            bclk_q <= bclk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            lr_prev  <= 1'b1;
            eff_last <= 1'b0;
            seen     <= 1'b0;
            len_ok_q <= 1'b0;
            pos_q    <= '0;
            len_q    <= '0;
        end else if (tick) begin
            lr_prev  <= lrck;
            eff_last <= eff_now;
            if (flip) begin
                pos_q <= '0;
                seen  <= 1'b1;
                if (seen) begin
                    len_q    <= len_new;
                    len_ok_q <= 1'b1;
                end
            end else begin
                pos_q <= pos_step(pos_q);
            end
        end
    end

    always_comb begin
        slot.tick       = tick & ~pd;
        slot.is_left    = eff_now;
        slot.left_start = tick & flip & eff_now & ~pd;
        slot.pos        = flip ? '0 : pos_step(pos_q);
        slot.len_ok     = (flip & seen) | len_ok_q;
        slot.half_len   = (flip & seen) ? len_new : len_q;
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R1

    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        len_ok_q |-> (len_q != '0)); // R4

endmodule

// File: rtl/pcm_tx_bitsel.sv
module pcm_tx_bitsel
    import pcm_tx_pkg::*;
(
    input  frame_fmt_e       fmt,
    input  word_len_e        wlen,
    input  logic [POS_W-1:0] pos,
    input  logic [LEN_W-1:0] half_len,
    input  logic             len_ok,
    output bit_sel_t         sel
);

    int unsigned w;
    int unsigned p;
    int unsigned n;

    always_comb begin
        w   = word_bits(wlen);
        p   = int'(pos);
        n   = int'(half_len);
        sel = '0;
        case (fmt)
            FMT_LJ, FMT_I2S: begin
                if (p < w) begin
                    sel.active = 1'b1;
                    sel.idx    = IDX_W'(p);
                end
            end
            FMT_RJ: begin
                if (len_ok && (n >= w) && (p + w >= n) && (p < n)) begin
                    sel.active = 1'b1;
                    sel.idx    = IDX_W'(p + w - n);
                end
            end
            default: sel = '0;
        endcase
    end

endmodule

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
    import pcm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pd,
    input  logic             park,
    input  logic             tick,
    input  logic             is_left,
    input  logic             left_start,
    input  bit_sel_t         sel,
    input  logic [SMP_W-1:0] smp_l,
    input  logic [SMP_W-1:0] smp_r,
    output logic             sdo
);

    logic [SMP_W-1:0] held_l;
    logic [SMP_W-1:0] held_r;
    logic [SMP_W-1:0] src;
    logic [IDX_W-1:0] bit_pos;
    logic             sdo_q;

    always_comb begin
        src     = is_left ? (left_start ? smp_l : held_l) : held_r;
        bit_pos = IDX_W'(SMP_W - 1) - sel.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_l <= '0;
            held_r <= '0;
        end else if (tick && left_start) begin
            held_l <= smp_l;
            held_r <= smp_r;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || pd || park) begin
            sdo_q <= 1'b0;
        end else if (tick) begin
            sdo_q <= sel.active & src[bit_pos];
        end
    end

    assign sdo = sdo_q;

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (rst)
        (!tick && !pd && !park) |=> $stable(sdo_q)); // R1

    AST_PARKED_LOW: assert property (@(posedge clk) disable iff (rst)
        park |=> !sdo_q); // R8

endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
    import pcm_tx_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 3,
    parameter int unsigned QUAD_LINES = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       pwr_down,
    input  logic [1:0]                 fmt_sel,
    input  logic [1:0]                 wlen_sel,
    input  logic                       quad_mode,
    input  logic                       bclk,
    input  logic                       lrck,
    input  logic [NUM_LINES*SMP_W-1:0] smp_left,
    input  logic [NUM_LINES*SMP_W-1:0] smp_right,
    output logic                       smp_take,
    output logic [NUM_LINES-1:0]       sdo
);

    frame_fmt_e fmt;
    word_len_e  wlen;
    slot_t      slot;
    bit_sel_t   sel;
    logic       rsvd;
    logic       take_q;

    always_comb begin
        fmt  = frame_fmt_e'(fmt_sel);
        wlen = word_len_e'(wlen_sel);
        rsvd = (fmt == FMT_RSVD);
    end

    pcm_tx_timebase u_tb (
        .clk  (clk),
        .rst  (rst),
        .pd   (pwr_down),
        .fmt  (fmt),
        .bclk (bclk),
        .lrck (lrck),
        .slot (slot)
    );

    pcm_tx_bitsel u_sel (
        .fmt      (fmt),
        .wlen     (wlen),
        .pos      (slot.pos),
        .half_len (slot.half_len),
        .len_ok   (slot.len_ok),
        .sel      (sel)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_lane
        localparam bit QUAD_OFF = (g >= QUAD_LINES);
        logic park;

        always_comb park = rsvd | (QUAD_OFF & quad_mode);

        pcm_tx_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .pd         (pwr_down),
            .park       (park),
            .tick       (slot.tick),
            .is_left    (slot.is_left),
            .left_start (slot.left_start),
            .sel        (sel),
            .smp_l      (smp_left[g*SMP_W +: SMP_W]),
            .smp_r      (smp_right[g*SMP_W +: SMP_W]),
            .sdo        (sdo[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_q <= 1'b0;
        end else begin
            take_q <= slot.left_start;
        end
    end

    assign smp_take = take_q;

    AST_PD_QUIET: assert property (@(posedge clk) disable iff (rst)
        pwr_down |=> ((sdo == '0) && !smp_take)); // R9

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (fmt_sel == 2'd1) |=> (sdo == '0)); // R5

    AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
        smp_take |=> !smp_take); // R7

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> ((sdo == '0) && !smp_take)); // R10

endmodule

// File: tb/sim_pcm_serial_tx.sv
module sim_pcm_serial_tx;

    localparam int NL = 3;
    localparam int SW = 24;
    localparam int NF = 3;
    localparam int NV = 13;

    // {quad, fmt, wlen, bit clocks per half}
    localparam logic [10:0] VEC [NV] = '{
        {1'b0, 2'd2, 2'd3, 6'd32},
        {1'b0, 2'd2, 2'd0, 6'd16},
        {1'b0, 2'd3, 2'd3, 6'd32},
        {1'b0, 2'd3, 2'd0, 6'd16},
        {1'b0, 2'd0, 2'd0, 6'd16},
        {1'b0, 2'd0, 2'd1, 6'd18},
        {1'b0, 2'd0, 2'd2, 6'd20},
        {1'b0, 2'd0, 2'd3, 6'd24},
        {1'b0, 2'd0, 2'd3, 6'd32},
        {1'b0, 2'd2, 2'd1, 6'd32},
        {1'b1, 2'd2, 2'd2, 6'd32},
        {1'b1, 2'd3, 2'd2, 6'd32},
        {1'b0, 2'd1, 2'd3, 6'd32}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pwr_down = 1'b1;
    logic [1:0]    fmt_sel = 2'd2;
    logic [1:0]    wlen_sel = 2'd3;
    logic          quad_mode = 1'b0;
    logic          bclk = 1'b1;
    logic          lrck = 1'b0;
    logic [NL*SW-1:0] smp_left = '0;
    logic [NL*SW-1:0] smp_right = '0;
    logic          smp_take;
    logic [NL-1:0] sdo;

    int checks = 0;
    int failures = 0;
    int takes = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcm_serial_tx u0 (
        .clk       (clk),
        .rst       (rst),
        .pwr_down  (pwr_down),
        .fmt_sel   (fmt_sel),
        .wlen_sel  (wlen_sel),
        .quad_mode (quad_mode),
        .bclk      (bclk),
        .lrck      (lrck),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .smp_take  (smp_take),
        .sdo       (sdo)
    );

    always @(posedge clk) if (!rst && smp_take === 1'b1) takes++;

    function automatic logic [23:0] pat(input int f, input int l, input int c);
        logic [23:0] v;
        v = 24'hA5C396 ^ (24'(f) * 24'h13579B) ^ (24'(l) * 24'h2C4E1F);
        if (c != 0) v = v ^ 24'hF00F35;
        return v;
    endfunction

    function automatic int wbits(input int code);
        return (code == 0) ? 16 : (code == 1) ? 18 : (code == 2) ? 20 : 24;
    endfunction

    // Expected bit at bit clock q of a half-frame (q counted from the frame clock edge)
    function automatic logic exp_bit(input int fmt, input int w, input int nb, input int q,
                                     input logic [23:0] cur, input logic [23:0] prv);
        case (fmt)
            2: return (q < w) ? cur[23-q] : 1'b0;
            3: begin
                if (q == 0) return (nb == w) ? prv[24-w] : 1'b0;
                return (q <= w) ? cur[24-q] : 1'b0;
            end
            0: return (q >= nb - w) ? cur[23-(q-(nb-w))] : 1'b0;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, got, exp);
        end
    endtask

    task automatic load_frame(input int f);
        for (int l = 0; l < NL; l++) begin
            smp_left[l*SW +: SW]  = pat(f, l, 0);
            smp_right[l*SW +: SW] = pat(f, l, 1);
        end
    endtask

    task automatic enter_pd(input int fmt, input int wl, input int qm, input int f0);
        @(negedge clk);
        pwr_down  = 1'b1;
        bclk      = 1'b1;
        fmt_sel   = 2'(fmt);
        wlen_sel  = 2'(wl);
        quad_mode = qm[0];
        lrck      = (fmt == 3) ? 1'b1 : 1'b0;
        load_frame(f0);
        repeat (3) @(negedge clk);
        pwr_down = 1'b0;
        takes    = 0;
        @(negedge clk);
    endtask

    task automatic run_cfg(input int fmt, input int wl, input int nb, input int qm);
        int w;
        string rq;
        logic [NL-1:0] held;
        logic e;
        w  = wbits(wl);
        rq = (fmt == 2) ? "R2" : (fmt == 3) ? "R3" : (fmt == 0) ? "R4" : "R5";
        enter_pd(fmt, wl, qm, 0);
        for (int f = 0; f < NF; f++) begin
            for (int h = 0; h < 2; h++) begin
                for (int q = 0; q < nb; q++) begin
                    bclk = 1'b0;
                    if (q == 0) begin
                        lrck = (fmt == 3) ? (h == 1) : (h == 0);
                        if (h == 1) load_frame(f + 1); // R7: late change must not reach right channel
                    end
                    @(negedge clk);
                    if (f > 0 || (fmt == 0 && h == 0)) begin
                        for (int l = 0; l < NL; l++) begin
                            if (qm != 0 && l == NL - 1) e = 1'b0;
                            else if (f == 0) e = 1'b0;
                            else e = exp_bit(fmt, w, nb, q, pat(f, l, h),
                                             (h == 0) ? pat(f - 1, l, 1) : pat(f, l, 0));
                            chk((qm != 0 && l == NL - 1) ? "R8" : {rq, " R6 R7"},
                                32'(sdo[l]), 32'(e));
                        end
                    end
                    held = sdo;
                    bclk = 1'b1;
                    @(negedge clk);
                    @(negedge clk);
                    chk("R1 hold", 32'(sdo), 32'(held));
                    @(negedge clk);
                end
            end
        end
        chk("R7 take count", 32'(takes), 32'(NF));
    endtask

    initial begin
        int tb0;
        logic [NL-1:0] held;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 sdo in reset", 32'(sdo), 32'd0);
        chk("R10 take in reset", 32'(smp_take), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 sdo after reset", 32'(sdo), 32'd0);
        chk("R10 take after reset", 32'(smp_take), 32'd0);

        for (int v = 0; v < NV; v++) begin
            run_cfg(int'(VEC[v][9:8]), int'(VEC[v][7:6]), int'(VEC[v][5:0]), int'(VEC[v][10]));
        end

        // R9: power-down mid-stream, then restart
        enter_pd(2, 3, 0, 5);
        for (int q = 0; q < 10; q++) begin
            bclk = 1'b0;
            if (q == 0) lrck = 1'b1;
            @(negedge clk);
            bclk = 1'b1;
            repeat (3) @(negedge clk);
        end
        pwr_down = 1'b1;
        @(negedge clk);
        chk("R9 lines low", 32'(sdo), 32'd0);
        tb0 = takes;
        for (int q = 0; q < 40; q++) begin
            bclk = 1'b0;
            if (q % 20 == 0) lrck = ~lrck;
            @(negedge clk);
            chk("R9 lines low", 32'(sdo), 32'd0);
            bclk = 1'b1;
            repeat (3) @(negedge clk);
        end
        chk("R9 no take", 32'(takes), 32'(tb0));
        lrck = 1'b0;
        load_frame(6);
        @(negedge clk);
        pwr_down = 1'b0;
        @(negedge clk);
        for (int q = 0; q < 24; q++) begin
            bclk = 1'b0;
            if (q == 0) lrck = 1'b1;
            @(negedge clk);
            for (int l = 0; l < NL; l++) begin
                chk("R9 restart", 32'(sdo[l]), 32'(pat(6, l, 0) >> (23 - q)) & 32'd1);
            end
            held = sdo;
            bclk = 1'b1;
            repeat (3) @(negedge clk);
            chk("R1 hold", 32'(sdo), 32'(held));
        end
        chk("R9 take after restart", 32'(takes), 32'(tb0 + 1));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule